// File: doc/BRIEF.md
# Strobe-Timed SRAM Bus Controller

This block turns single host read and write requests into the strobe sequence needed by an asynchronous static memory that captures its address when the active-low enable strobe falls. Each access runs through four phases: idle, address setup with the enable high, strobe low, and strobe high for precharge. The number of clocks in each phase comes from parameters. The host sees a busy flag while an access is under way, and a one-clock valid pulse that comes with the read data.

Write accesses lower the write strobe no later than the enable falls, and raise it no earlier than the enable rises. The memory output therefore never turns on during a write. Write data is driven from the moment the write strobe is low until the access ends, so the data meets its setup and hold against the rising edge of the enable. If writes follow one another, the write strobe stays low between them and only the enable toggles.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and right after reset, mem_e_o and mem_w_o are 1, and busy_o, mem_dq_oe_o and rvalid_o are 0.
- R2: A request with req_i high is accepted on a clock edge where busy_o is 0. busy_o is 1 from the next cycle until the strobe-high phase ends. The access then occupies SU+LW+HW cycles. SU is max(T_SETUP,1). LW is max(T_LOW,T_HOLD,T_ACCESS+1). HW is max(T_HIGH, T_CYCLE-LW-SU-1, 1).
- R3: mem_a_o takes the accepted address in the first busy cycle and holds it through the rest of the access. The enable is therefore high with a stable address for SU cycles before it falls, and the address stays put while the enable is low.
- R4: mem_e_o (active low) is 0 for exactly LW consecutive cycles of each access, starting SU cycles after acceptance. At no other time is it 0.
- R5: Two successive falling edges of mem_e_o are at least SU+LW+HW+1 cycles apart, which is at least T_CYCLE.
- R6: A read (we_i=0) sets mem_w_o to 1 in its first busy cycle, so mem_w_o is 1 for the whole read access.
- R7: A write (we_i=1) sets mem_w_o to 0 in its first busy cycle. mem_w_o changes only at request acceptance, which is a point where mem_e_o is high.
- R8: mem_dq_oe_o is 1 from the first busy cycle of a write until busy_o drops. It is 0 at all other times, and therefore 0 throughout every read.
- R9: rvalid_o pulses for one cycle, in the cycle right after the last strobe-low cycle of a read. In that cycle rdata_o holds the value of mem_dq_i sampled at the end of the strobe-low phase. rvalid_o never pulses for a write.
- R10: Between back-to-back writes, mem_w_o stays 0 while mem_e_o toggles once per write.
- R11: A request made while busy_o is 1 is ignored. It changes neither the address, nor the data, nor the kind of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| busy_o | output | 1 | Access in progress |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_e_o | output | 1 | Memory enable strobe, active low |
| mem_w_o | output | 1 | Memory write strobe, active low |
| mem_a_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for the shared data bus |
| mem_dq_i | input | DATA_W | Data sampled from memory |

## Verification
The assertions assume that mem_dq_i is stable during the last strobe-low cycle of a read. They also assume that the host keeps req_i, we_i, addr_i and wdata_i steady around the accepting clock edge. The bench models the memory behaviourally. That model drives mem_dq_i only while the enable is low and the write strobe is high, and it updates its contents only when the enable rises with the write strobe low. The bench changes host inputs only on falling clock edges. It keeps req_i high across busy periods on purpose, to check that such requests are ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int T_SETUP  = 1,
  parameter int T_HOLD   = 1,
  parameter int T_LOW    = 3,
  parameter int T_ACCESS = 2,
  parameter int T_HIGH   = 2,
  parameter int T_CYCLE  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_e_o,
  output logic              mem_w_o,
  output logic [ADDR_W-1:0] mem_a_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int SU    = max2(T_SETUP, 1);
  localparam int LW    = max2(max2(T_LOW, T_HOLD), T_ACCESS + 1);
  localparam int HW    = max2(max2(T_HIGH, T_CYCLE - LW - SU - 1), 1);
  localparam int CNT_W = $clog2(max2(max2(SU, LW), HW) + 1);

  phase_e            ph_q;
  logic              e_q, w_q, oe_q, wr_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              accept, done, load;
  logic [CNT_W-1:0]  load_val;

  assign accept = (ph_q == PH_IDLE) && req_i;
  assign load   = accept || ((ph_q != PH_IDLE) && done);

  always_comb begin
    unique case (ph_q)
      PH_IDLE:  load_val = CNT_W'(SU - 1);
      PH_SETUP: load_val = CNT_W'(LW - 1);
      PH_LOW:   load_val = CNT_W'(HW - 1);
      default:  load_val = '0;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE;
      e_q  <= 1'b1;
      w_q  <= 1'b1;
      oe_q <= 1'b0;
      wr_q <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (accept) begin
          ph_q <= PH_SETUP;
          a_q  <= addr_i;
          d_q  <= wdata_i;
          wr_q <= we_i;
          w_q  <= ~we_i;   // W moves only while E is high
          oe_q <= we_i;
        end
        PH_SETUP: if (done) begin
          ph_q <= PH_LOW;
          e_q  <= 1'b0;
        end
        PH_LOW: if (done) begin
          ph_q <= PH_HIGH;
          e_q  <= 1'b1;
        end
        default: if (done) begin
          ph_q <= PH_IDLE;
          oe_q <= 1'b0;    // W left low to allow chained writes
        end
      endcase
    end
  end

  sram_read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    ((ph_q == PH_LOW) && done && !wr_q),
    .dq_i     (mem_dq_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );

  assign busy_o      = (ph_q != PH_IDLE);
  assign mem_e_o     = e_q;
  assign mem_w_o     = w_q;
  assign mem_a_o     = a_q;
  assign mem_dq_o    = d_q;
  assign mem_dq_oe_o = oe_q;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter int T_LOW  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              rvalid_o,
  input logic              mem_e_o,
  input logic              mem_w_o,
  input logic              mem_dq_oe_o,
  input logic [ADDR_W-1:0] mem_a_o
);
  int low_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_len <= 0;
    else if (!mem_e_o) low_len <= low_len + 1;
    else               low_len <= 0;
  end

  AST_IDLE_E_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> mem_e_o);                                   // R2
  AST_ADDR_BEFORE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_e_o) |-> $stable(mem_a_o));                   // R3
  AST_ADDR_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_e_o && !$fell(mem_e_o)) |-> $stable(mem_a_o));    // R3
  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_e_o) |-> (low_len >= T_LOW));                 // R4
  AST_W_ONLY_E_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_w_o) |-> (mem_e_o && $past(mem_e_o)));     // R7
  AST_READ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_e_o && mem_w_o) |-> !mem_dq_oe_o);                // R8
  AST_WRITE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_e_o && !mem_w_o) |-> mem_dq_oe_o);                // R8
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);                                // R9
  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($rose(mem_e_o) && mem_w_o));              // R9
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W), .T_LOW(T_LOW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .rvalid_o    (rvalid_o),
  .mem_e_o     (mem_e_o),
  .mem_w_o     (mem_w_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_a_o     (mem_a_o)
);

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;
  localparam int AW = 10, DW = 4;
  localparam int SU = 1, LW = 3, HW = 3, TOT = SU + LW + HW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, rvalid, e, w, oe;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [AW-1:0] a;

  always #2.5 clk = ~clk;

  sram_strobe_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_e_o(e), .mem_w_o(w), .mem_a_o(a), .mem_dq_o(dq_o),
    .mem_dq_oe_o(oe), .mem_dq_i(dq_i)
  );

  // behavioural memory device
  logic [DW-1:0] dev [1<<AW];
  logic [AW-1:0] dev_a;
  initial begin
    for (int i = 0; i < (1<<AW); i++) dev[i] = DW'(i * 7 + 3);
    dev_a = '0;
  end
  always @(negedge e) dev_a = a;
  always @(posedge e) if (!w && oe) dev[dev_a] = dq_o;
  assign dq_i = (!e && w) ? dev[dev_a] : '0;

  // reference model
  logic [DW-1:0] gold [1<<AW];
  initial for (int i = 0; i < (1<<AW); i++) gold[i] = DW'(i * 7 + 3);
  int t = -1;
  bit m_we = 0, m_w = 1, m_rv = 0;
  logic [AW-1:0] m_a = '0;
  logic [DW-1:0] m_d = '0, m_rd = '0;
  int last_fall = -100, cyc = 0;

  int checks = 0, errors = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      t = -1; m_w = 1; m_rv = 0; m_we = 0;
    end else begin
      m_rv = 0;
      if (t >= 0) begin
        t++;
        if (t == SU + LW && !m_we) m_rv = 1;
        if (t == TOT) t = -1;
      end else if (req) begin
        t = 0; m_we = we; m_a = addr; m_d = wdata; m_w = !we;
        if (we) gold[addr] = wdata;
        m_rd = gold[addr];
      end
    end
  end

  task automatic chk(input string rq, input string nm, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0d", rq, nm, act, exp, t);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "e", int'(e), 1);  chk("R1", "w", int'(w), 1);
      chk("R1", "busy", int'(busy), 0); chk("R1", "oe", int'(oe), 0);
      chk("R1", "rvalid", int'(rvalid), 0);
    end else begin
      chk("R2", "busy", int'(busy), int'(t >= 0));
      chk("R4", "e", int'(e), int'(!(t >= SU && t < SU + LW)));
      chk("R7", "w", int'(w), int'(m_w));
      chk("R8", "oe", int'(oe), int'(t >= 0 && m_we));
      chk("R9", "rvalid", int'(rvalid), int'(m_rv));
      if (t >= 0) chk("R3", "addr", int'(a), int'(m_a));
      if (t >= 0 && m_we) chk("R11", "wdata", int'(dq_o), int'(m_d));
      if (m_rv) chk("R9", "rdata", int'(rdata), int'(m_rd));
      if (t >= 0 && !m_we) chk("R6", "w_read", int'(w), 1);
      if (t == SU) begin
        if (last_fall >= 0) chk("R5", "fall_gap", int'(cyc - last_fall >= TOT + 1), 1);
        last_fall = cyc;
      end
    end
  end

  task automatic op(input bit wr, input int ad, input int dt);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; we = wr; addr = AW'(ad); wdata = DW'(dt);
    @(negedge clk);
    req = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R6 R9 reads of initial contents
    op(0, 0, 0); op(0, 1023, 0); op(0, 17, 0);
    // R7 R8 writes at boundaries
    op(1, 0, 9); op(1, 1023, 6); op(1, 512, 15);
    op(0, 0, 0); op(0, 1023, 0); op(0, 512, 0);
    // R10 back-to-back writes, W stays low
    op(1, 3, 1); op(1, 4, 2); op(1, 5, 3);
    op(0, 3, 0); op(0, 4, 0); op(0, 5, 0);
    settle();
    // R11 request held while busy: only first accepted per idle slot
    @(negedge clk);
    req = 1; we = 1; addr = 10'd100; wdata = 4'd12;
    @(negedge clk);
    addr = 10'd200; wdata = 4'd5; we = 0;
    repeat (3) @(negedge clk);
    req = 0;
    settle();
    op(0, 100, 0); op(0, 200, 0);
    settle();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule